// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block takes the already demodulated output of an infrared receiver and records the raw shape of a remote-control message. It samples the input on a programmable sample tick and rejects short glitches with a de-glitch filter. It then measures each high interval (pulse) and each low interval (space) in sample ticks. Each width is stored as one byte in a bank of 32-bit capture words that software reads back. The bytes alternate pulse, space, pulse and so on, beginning with a pulse.

A message ends when a space lasts longer than a programmed end count. The block then writes a zero byte, stops capturing and raises an interrupt. Software reads the bank, decodes the protocol itself, acknowledges the interrupt and writes a restart. The restart empties the bank and re-arms the receiver.

Top module: `ir_capture_ctrl`

## Requirements
- R1: Capture word i is read at address 0x40 + 4*i (i = 0..16). Entry n (counted from 0 in arrival order) is in word n/4, at bits 8*(n%4)+7 : 8*(n%4). Entries alternate pulse, space, pulse, and entry 0 is the first pulse.
- R2: The sample tick fires once every PERIOD+1 clocks, where PERIOD is bits 15:0 of register 0x04. A stored width is the number of ticks between two accepted edges. For an input held n ticks at each level, the stored width is n.
- R3: A width of more than 255 ticks is stored as 0xFF.
- R4: The end count is bits 22:16 of the configuration register at 0x00. A space longer than the end count stores a zero entry, completes the message and sets the interrupt pending flag.
- R5: The bank holds 68 entries. Intervals after the 68th are dropped, and a later long space still completes the message.
- R6: The de-glitch count is bits 12:8 of register 0x08 (a value of 0 acts as 1). A level change is accepted only after that many consecutive samples at the new level. Shorter excursions are merged into the interval around them.
- R7: Writing 1 to bit 0 of register 0x0C zeroes every capture word and returns the receiver to waiting for a first pulse.
- R8: Once a message is complete, input edges leave the bank unchanged until a restart.
- R9: irq = pending AND bit 0 of register 0x10. Writing 1 to bit 0 of register 0x14 clears pending. When both happen in one cycle, setting pending wins.
- R10: Capture runs only while configuration bit 0 (receiver enable) and bit 13 (width detection enable) are both 1. Otherwise no entry is written and no message completes.
- R11: After reset all registers read 0, all capture words read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational from addr |
| ir_in | input | 1 | Demodulated infrared input, high = pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after width counting at the tick boundary. An off-by-one in the restart of the width counter would shift every stored byte by one. A pulse of several hundred ticks checks saturation, since a wrapping counter would store a small value instead of 0xFF. A glitch shorter than the de-glitch count is placed inside a space: a filter that accepts it early would split one space into three entries. A message of more than 68 intervals, followed by edges after completion, is used too. Overrunning the bank would corrupt the last word or lose the interrupt, and a receiver that keeps capturing after completion would overwrite the stored message.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    localparam int BYTE_W        = 8;
    localparam int DATA_W        = 32;
    localparam int BYTES_PER_WRD = DATA_W / BYTE_W;
    localparam int DG_W          = 5;
    localparam int ENDCNT_W      = 7;

    // register byte addresses
    localparam logic [7:0] A_CONFIG  = 8'h00;
    localparam logic [7:0] A_PERIOD  = 8'h04;
    localparam logic [7:0] A_THRESH  = 8'h08;
    localparam logic [7:0] A_RESTART = 8'h0C;
    localparam logic [7:0] A_INTEN   = 8'h10;
    localparam logic [7:0] A_INTCLR  = 8'h14;
    localparam logic [7:0] A_BANK    = 8'h40;

    // configuration field positions
    localparam int CFG_RX_EN_BIT  = 0;
    localparam int CFG_PWD_EN_BIT = 13;
    localparam int CFG_END_LSB    = 16;
    localparam int THR_DG_LSB     = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } meas_state_t;

    typedef struct packed {
        logic                rx_en;
        logic                pwd_en;
        logic [ENDCNT_W-1:0] end_cnt;
        logic [DG_W-1:0]     dg_cnt;
    } cap_cfg_t;

    function automatic logic [BYTE_W-1:0] sat_inc(input logic [BYTE_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                clr,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !en)
            div_q <= '0;
        else if (div_q >= period)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = en && (div_q >= period);
endmodule

// File: rtl/ir_deglitch.sv
module ir_deglitch
    import ir_cap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    input  logic            din,
    input  logic [DG_W-1:0] dg,
    output logic            level,
    output logic            rise,
    output logic            fall
);
    logic            lvl_q;
    logic [DG_W-1:0] run_q;
    logic [DG_W-1:0] dg_eff;
    logic            accept;

    assign dg_eff = (dg == '0) ? DG_W'(1) : dg;
    assign accept = tick && (din != lvl_q) &&
                    (({1'b0, run_q} + 1'b1) >= {1'b0, dg_eff});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (tick) begin
            if (din == lvl_q) begin
                run_q <= '0;
            end else if (accept) begin
                lvl_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level = lvl_q;
    assign rise  = accept && din;
    assign fall  = accept && !din;
endmodule

// File: rtl/ir_width_meas.sv
module ir_width_meas
    import ir_cap_pkg::*;
#(
    parameter int NUM_ENTRIES = 68,
    parameter int IDX_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                run,
    input  logic                tick,
    input  logic                rise,
    input  logic                fall,
    input  logic                level,
    input  logic [ENDCNT_W-1:0] end_cnt,
    output logic                we,
    output logic [IDX_W-1:0]    widx,
    output logic [BYTE_W-1:0]   wdata,
    output logic                msg_end,
    output logic                done
);
    meas_state_t       st_q, st_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [BYTE_W-1:0] cnt_q, cnt_n;
    logic              room;

    assign room = (idx_q < IDX_W'(NUM_ENTRIES));

    always_comb begin
        st_n    = st_q;
        idx_n   = idx_q;
        cnt_n   = cnt_q;
        we      = 1'b0;
        wdata   = '0;
        msg_end = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (run && rise) begin
                    st_n  = ST_MEAS;
                    cnt_n = BYTE_W'(1);
                end
            end
            ST_MEAS: begin
                if (run && tick) begin
                    if (rise || fall) begin
                        we    = room;
                        wdata = cnt_q;
                        if (room) idx_n = idx_q + 1'b1;
                        cnt_n = BYTE_W'(1);
                    end else if (!level && (cnt_q >= {1'b0, end_cnt})) begin
                        we      = room;
                        wdata   = '0;
                        if (room) idx_n = idx_q + 1'b1;
                        msg_end = 1'b1;
                        st_n    = ST_DONE;
                    end else begin
                        cnt_n = sat_inc(cnt_q);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            idx_q <= idx_n;
            cnt_q <= cnt_n;
        end
    end

    assign widx = idx_q;
    assign done = (st_q == ST_DONE);
endmodule

// File: rtl/ir_capture_bank.sv
module ir_capture_bank
    import ir_cap_pkg::*;
#(
    parameter int NUM_WORDS   = 17,
    parameter int NUM_ENTRIES = NUM_WORDS * BYTES_PER_WRD,
    parameter int IDX_W       = $clog2(NUM_ENTRIES + 1),
    parameter int WORD_W      = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_ok,
    input  logic [WORD_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_word
);
    logic [BYTE_W-1:0] ent_q [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[widx] <= wdata;
        end
    end

    for (genvar k = 0; k < BYTES_PER_WRD; k++) begin : g_lane
        logic [WORD_W+1:0] pos;
        assign pos = {rd_sel, 2'(k)};
        assign rd_word[BYTE_W*k +: BYTE_W] = rd_ok ? ent_q[pos] : '0;
    end
endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
    import ir_cap_pkg::*;
#(
    parameter int NUM_WORDS = 17,
    parameter int PERIOD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              ir_in,
    output logic              irq
);
    localparam int NUM_ENTRIES = NUM_WORDS * BYTES_PER_WRD;
    localparam int IDX_W       = $clog2(NUM_ENTRIES + 1);
    localparam int WORD_W      = $clog2(NUM_WORDS);
    localparam int BANK_BYTES  = NUM_WORDS * BYTES_PER_WRD;

    logic [31:0] cfg_q, period_q, thr_q, inten_q;
    logic        pending_q;
    cap_cfg_t    cfg;
    logic        restart_wr, clear_wr;
    logic [1:0]  sync_q;

    logic                tick, level, rise, fall;
    logic                we_w, msg_end_w, done_w;
    logic [IDX_W-1:0]    idx_w;
    logic [BYTE_W-1:0]   wdata_w;
    logic                bank_hit;
    logic [7:0]          bank_off;
    logic [DATA_W-1:0]   bank_word;

    assign cfg.rx_en   = cfg_q[CFG_RX_EN_BIT];
    assign cfg.pwd_en  = cfg_q[CFG_PWD_EN_BIT];
    assign cfg.end_cnt = cfg_q[CFG_END_LSB +: ENDCNT_W];
    assign cfg.dg_cnt  = thr_q[THR_DG_LSB +: DG_W];

    assign restart_wr = wr_en && (addr == A_RESTART) && wr_data[0];
    assign clear_wr   = wr_en && (addr == A_INTCLR) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            period_q <= '0;
            thr_q    <= '0;
            inten_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CONFIG: cfg_q    <= wr_data;
                A_PERIOD: period_q <= wr_data;
                A_THRESH: thr_q    <= wr_data;
                A_INTEN:  inten_q  <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], ir_in};
    end

    ir_tick_gen #(.PERIOD_W(PERIOD_W)) tick_i (
        .clk(clk), .rst(rst), .en(cfg.rx_en), .clr(restart_wr),
        .period(period_q[PERIOD_W-1:0]), .tick(tick)
    );

    ir_deglitch dg_i (
        .clk(clk), .rst(rst), .clr(restart_wr), .tick(tick),
        .din(sync_q[1]), .dg(cfg.dg_cnt),
        .level(level), .rise(rise), .fall(fall)
    );

    ir_width_meas #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) meas_i (
        .clk(clk), .rst(rst), .clr(restart_wr),
        .run(cfg.rx_en && cfg.pwd_en), .tick(tick),
        .rise(rise), .fall(fall), .level(level), .end_cnt(cfg.end_cnt),
        .we(we_w), .widx(idx_w), .wdata(wdata_w),
        .msg_end(msg_end_w), .done(done_w)
    );

    assign bank_off = addr - A_BANK;
    assign bank_hit = (addr >= A_BANK) && (bank_off < 8'(BANK_BYTES));

    ir_capture_bank #(
        .NUM_WORDS(NUM_WORDS), .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W(IDX_W), .WORD_W(WORD_W)
    ) bank_i (
        .clk(clk), .rst(rst), .clr(restart_wr),
        .we(we_w), .widx(idx_w), .wdata(wdata_w),
        .rd_ok(bank_hit), .rd_sel(bank_off[WORD_W+1:2]),
        .rd_word(bank_word)
    );

    always_ff @(posedge clk) begin
        if (rst)            pending_q <= 1'b0;
        else if (msg_end_w) pending_q <= 1'b1;
        else if (clear_wr)  pending_q <= 1'b0;
    end

    assign irq = pending_q && inten_q[0];

    always_comb begin
        if (bank_hit) begin
            rd_data = bank_word;
        end else begin
            unique case (addr)
                A_CONFIG: rd_data = cfg_q;
                A_PERIOD: rd_data = period_q;
                A_THRESH: rd_data = thr_q;
                A_INTEN:  rd_data = inten_q;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ir_capture_ctrl_chk.sv
module ir_capture_ctrl_chk #(
    parameter int NUM_ENTRIES = 68,
    parameter int IDX_W       = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wr_data,
    input logic             irq,
    input logic [IDX_W-1:0] idx,
    input logic             done,
    input logic             msg_end,
    input logic             we,
    input logic [7:0]       wdata
);
    logic restart_seen, clear_seen;
    assign restart_seen = wr_en && (addr == 8'h0C) && wr_data[0];
    assign clear_seen   = wr_en && (addr == 8'h14) && wr_data[0];

    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_W'(NUM_ENTRIES));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !restart_seen) |=> ($stable(idx) && done));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        restart_seen |=> (idx == '0 && !done));

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clear_seen && !msg_end) |=> !irq);

    assert_width_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !msg_end) |-> (wdata != 8'd0));

    assert_end_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (we && msg_end) |-> (wdata == 8'd0));
endmodule

bind ir_capture_ctrl ir_capture_ctrl_chk #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq(irq), .idx(idx_w), .done(done_w), .msg_end(msg_end_w),
    .we(we_w), .wdata(wdata_w)
);

// File: tb/ir_capture_ctrl_tb_top.sv
module ir_capture_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ir_in = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int per = 0;
    logic [7:0] exp_e [68];

    always #4 clk = ~clk;

    ir_capture_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ir_in(ir_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic hold(input logic lv, input int n);
        ir_in = lv;
        repeat (n * (per + 1)) @(negedge clk);
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 68; i++) exp_e[i] = 8'h00;
    endtask

    task automatic check_bank(input string req);
        logic [31:0] v;
        for (int w = 0; w < 17; w++) begin
            rd(8'h40 + 8'(4 * w), v);
            check(req, v, {exp_e[4*w+3], exp_e[4*w+2], exp_e[4*w+1], exp_e[4*w]});
        end
    endtask

    task automatic setup(input int p, input int dg, input int e, input logic ie);
        per = p;
        ir_in = 1'b0;
        wr(8'h04, 32'(p));
        wr(8'h08, 32'(dg) << 8);
        wr(8'h00, (32'(e) << 16) | 32'h2001);
        wr(8'h10, {31'b0, ie});
        wr(8'h14, 32'h1);
        repeat (4) @(negedge clk);
        wr(8'h0C, 32'h1);
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R11 config", v, 32'h0);
        rd(8'h08, v); check("R11 threshold", v, 32'h0);
        rd(8'h40, v); check("R11 word0", v, 32'h0);
        check("R11 irq", {31'b0, irq}, 32'h0);
    endtask

    // basic message, interrupt gating and clear
    task automatic test_basic();
        setup(3, 1, 20, 1'b0);
        hold(1, 9); hold(0, 4); hold(1, 3); hold(0, 6); hold(1, 2); hold(0, 30);
        repeat (3) @(negedge clk);
        clear_exp();
        exp_e[0] = 9; exp_e[1] = 4; exp_e[2] = 3; exp_e[3] = 6; exp_e[4] = 2; exp_e[5] = 0;
        check_bank("R1 R2 R4 packing and widths");
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h1);
        #1 check("R4 R9 irq after enable", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h1);
        #1 check("R9 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_saturate();
        setup(0, 1, 10, 1'b1);
        hold(1, 300); hold(0, 3); hold(1, 1); hold(0, 20);
        repeat (3) @(negedge clk);
        clear_exp();
        exp_e[0] = 8'hFF; exp_e[1] = 3; exp_e[2] = 1;
        check_bank("R3 saturation");
        check("R4 irq", {31'b0, irq}, 32'h1);
    endtask

    task automatic test_glitch();
        setup(1, 3, 30, 1'b1);
        hold(1, 6); hold(0, 5); hold(1, 2); hold(0, 5); hold(1, 4); hold(0, 50);
        repeat (3) @(negedge clk);
        clear_exp();
        exp_e[0] = 6; exp_e[1] = 12; exp_e[2] = 4;
        check_bank("R6 deglitch merge");
    endtask

    task automatic test_full_and_hold();
        setup(0, 1, 10, 1'b1);
        for (int i = 0; i < 40; i++) begin hold(1, 2); hold(0, 3); end
        hold(0, 20);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 68; i++) exp_e[i] = (i % 2 == 0) ? 8'd2 : 8'd3;
        check_bank("R5 full bank");
        check("R5 irq after overflow", {31'b0, irq}, 32'h1);
        hold(1, 5); hold(0, 7); hold(1, 4); hold(0, 20);
        check_bank("R8 ignored after done");
        wr(8'h14, 32'h1);
        wr(8'h0C, 32'h1);
        clear_exp();
        check_bank("R7 restart clears");
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic test_enables();
        logic [31:0] v;
        setup(0, 1, 10, 1'b1);
        wr(8'h00, (32'd10 << 16) | 32'h1);
        hold(1, 5); hold(0, 4); hold(1, 3); hold(0, 20);
        rd(8'h40, v); check("R10 width detect off", v, 32'h0);
        check("R10 irq width detect off", {31'b0, irq}, 32'h0);
        wr(8'h00, (32'd10 << 16) | 32'h2000);
        hold(1, 5); hold(0, 4); hold(1, 3); hold(0, 20);
        rd(8'h40, v); check("R10 receiver off", v, 32'h0);
        check("R10 irq receiver off", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_saturate();
        test_glitch();
        test_full_and_hold();
        test_enables();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule